// File: doc/BRIEF.md
# Phase-Offset Waveform Table Scaler

This block keeps four reference waveform tables in a dual-port memory and turns an electrical angle into one scaled duty value per motor phase. A processor-style access port can read and rewrite any table entry at any time. The second memory port is read-only and belongs to the lookup sequencer, so table updates and lookups never wait on each other.

A one-cycle start strobe captures the angle, the table select, the modulation magnitude and the drive mode. The sequencer then reads the selected table once per phase, each phase with its own fixed angle offset. Each entry is turned into a magnitude and multiplied by the modulation magnitude, and the top half of the product is kept, so the result never exceeds the magnitude. In three-phase mode there are three outputs. In two-coil mode there are two outputs, and each carries the sign of its entry as a polarity bit. A done pulse marks the cycle in which every duty output of the lookup is valid.

Top module: `wave_lut_scaler`

## Requirements
- R1: While reset is asserted, and after its release until the first lookup completes, every duty output, every polarity bit, done_o and acc_rdata_o read 0.
- R2: Memory addresses are 10 bits: bits [9:8] give the table and bits [7:0] give the entry within it. A cycle with acc_en_i=1 and acc_we_i=1 stores acc_wdata_i. A cycle with acc_en_i=1 and acc_we_i=0 presents the stored word on acc_rdata_o after the next rising edge. In every other cycle acc_rdata_o holds its value.
- R3: start_i is sampled on a rising edge only when no lookup is in progress. At that edge the block captures angle_i, tbl_sel_i, mdval_i and three_phase_i. A start_i seen during a lookup has no effect on that lookup's results.
- R4: For each phase, the entry index is bits [24:17] of (angle + offset) mod 2^25. In three-phase mode (three_phase_i=1) the offsets for phases 0, 1 and 2 are 0, 22369621 (240 degrees) and 11184810 (120 degrees).
- R5: In two-coil mode (three_phase_i=0) phase 0 uses offset 0 and phase 1 uses offset 25165824 (270 degrees). Phase 2 duty and polarity are driven to 0.
- R6: Each duty equals floor(mdval × magnitude / 131072), and at the done pulse no duty exceeds the captured mdval.
- R7: In three-phase mode an entry with bit 17 set (negative) gives magnitude 0. Any other entry gives its bits [16:0] as the magnitude. Every polarity bit is 0.
- R8: In two-coil mode the magnitude is the absolute value of the signed 18-bit entry, capped at 131071. The polarity bit of the phase equals entry bit 17.
- R9: With start sampled at rising edge 0 and N phases (3 or 2), done_o is high for exactly one cycle, after edge N+1. All duties are updated by then and hold until the next lookup writes them.
- R10: If the access port writes an entry on the same edge at which the sequencer reads it, the lookup uses the previous contents. Later lookups use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en_i | input | 1 | Access port enable |
| acc_we_i | input | 1 | Access port write (1) or read (0) |
| acc_addr_i | input | 10 | Access address: {table, entry} |
| acc_wdata_i | input | 18 | Signed write data |
| acc_rdata_o | output | 18 | Signed read data, one cycle after a read |
| start_i | input | 1 | One-cycle lookup strobe |
| three_phase_i | input | 1 | 1 = three-phase, 0 = two-coil |
| tbl_sel_i | input | 2 | Table used for the lookup |
| angle_i | input | 25 | Electrical angle, 2^25 = 360 degrees |
| mdval_i | input | 17 | Modulation magnitude |
| duty_o | output | 51 | Phase p duty in bits [17p+16:17p] |
| neg_o | output | 3 | Polarity per phase (two-coil) |
| done_o | output | 1 | One-cycle pulse, all duties valid |

## Verification
An access read has one register on its path, so its data is due one rising edge after the read cycle. A lookup passes through the capture register, the table read register and the duty register. Its duties and done pulse are therefore due after edge 4 (three-phase) or edge 3 (two-coil), counting from the edge that samples start. The bench drives every input on falling edges and samples on the falling edge that follows the edge where a result is due. It also confirms that done_o stays low at each earlier falling edge and drops one cycle later. The collision case places the write on the exact edge of the phase-0 read, then repeats the lookup to see the new data.

// File: rtl/wlut_pkg.sv
package wlut_pkg;

  localparam int unsigned NUM_PH = 3;

  typedef enum logic {
    MODE_TWO_COIL    = 1'b0,
    MODE_THREE_PHASE = 1'b1
  } wl_mode_e;

  // Angle offset of a phase as a fraction of the full turn 2^aw (floor).
  function automatic logic [63:0] phase_offset(input logic three,
                                               input int unsigned ph,
                                               input int unsigned aw);
    logic [63:0] full;
    logic [63:0] res;
    full = 64'd1 << aw;
    res  = 64'd0;
    if (three) begin
      if (ph == 1) res = (full * 64'd2) / 64'd3;
      else if (ph == 2) res = full / 64'd3;
    end else begin
      if (ph == 1) res = (full * 64'd3) / 64'd4;
    end
    return res;
  endfunction

endpackage

// File: rtl/wlut_mem.sv
module wlut_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] a_rdata_q, a_rdata_d;
  logic [DATA_W-1:0] b_rdata_q, b_rdata_d;
  logic              a_wr;

  assign a_wr = a_en & a_we;

  // Storage array: no reset, write through the access port only.
  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_comb begin
    a_rdata_d = a_rdata_q;
    if (a_en && !a_we) a_rdata_d = mem[a_addr];
    b_rdata_d = b_rdata_q;
    if (b_en) b_rdata_d = mem[b_addr];
  end

  // Read registers sample the array before this edge's write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata_q <= '0;
      b_rdata_q <= '0;
    end else begin
      a_rdata_q <= a_rdata_d;
      b_rdata_q <= b_rdata_d;
    end
  end

  assign a_rdata = a_rdata_q;
  assign b_rdata = b_rdata_q;
endmodule

// File: rtl/wlut_seq.sv
module wlut_seq
  import wlut_pkg::*;
#(
  parameter int ANGLE_W = 25,
  parameter int IDX_W   = 8,
  parameter int TBL_W   = 2,
  parameter int MAG_W   = 17,
  parameter int PH_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [ANGLE_W-1:0]     angle_i,
  input  logic [TBL_W-1:0]       tbl_i,
  input  logic [MAG_W-1:0]       mdval_i,
  input  logic                   three_i,
  output logic                   rd_en_o,
  output logic [TBL_W+IDX_W-1:0] rd_addr_o,
  output logic                   busy_o,
  output logic [MAG_W-1:0]       mdval_o,
  output logic                   three_o,
  output logic                   load_o,
  output logic [PH_W-1:0]        load_ph_o,
  output logic                   done_o
);
  localparam logic [ANGLE_W-1:0] OFS_3P_1 = ANGLE_W'(phase_offset(1'b1, 1, ANGLE_W));
  localparam logic [ANGLE_W-1:0] OFS_3P_2 = ANGLE_W'(phase_offset(1'b1, 2, ANGLE_W));
  localparam logic [ANGLE_W-1:0] OFS_2C_1 = ANGLE_W'(phase_offset(1'b0, 1, ANGLE_W));
  localparam int                 SHIFT    = ANGLE_W - IDX_W;

  logic                busy_q, busy_d;
  logic [PH_W-1:0]     cnt_q, cnt_d;
  logic [ANGLE_W-1:0]  ang_q, ang_d;
  logic [TBL_W-1:0]    tbl_q, tbl_d;
  logic [MAG_W-1:0]    md_q, md_d;
  logic                three_q, three_d;
  logic                vld_q, vld_d;
  logic [PH_W-1:0]     vph_q, vph_d;
  logic                done_q, done_d;
  logic                accept;
  logic [PH_W-1:0]     last_ph;
  logic [ANGLE_W-1:0]  ofs;
  logic [ANGLE_W-1:0]  sum;
  logic [IDX_W-1:0]    idx;

  assign accept  = start_i & ~busy_q;
  assign last_ph = three_q ? PH_W'(2) : PH_W'(1);

  always_comb begin
    ofs = '0;
    if (three_q == MODE_THREE_PHASE) begin
      if (cnt_q == PH_W'(1)) ofs = OFS_3P_1;
      else if (cnt_q == PH_W'(2)) ofs = OFS_3P_2;
    end else if (cnt_q == PH_W'(1)) begin
      ofs = OFS_2C_1;
    end
  end

  assign sum = ang_q + ofs;
  assign idx = IDX_W'(sum >> SHIFT);

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    ang_d   = ang_q;
    tbl_d   = tbl_q;
    md_d    = md_q;
    three_d = three_q;
    if (accept) begin
      busy_d  = 1'b1;
      cnt_d   = '0;
      ang_d   = angle_i;
      tbl_d   = tbl_i;
      md_d    = mdval_i;
      three_d = three_i;
    end else if (busy_q) begin
      cnt_d = cnt_q + PH_W'(1);
      if (cnt_q == last_ph) busy_d = 1'b0;
    end
    vld_d  = busy_q;
    vph_d  = cnt_q;
    done_d = vld_q & (vph_q == last_ph);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      ang_q   <= '0;
      tbl_q   <= '0;
      md_q    <= '0;
      three_q <= 1'b0;
      vld_q   <= 1'b0;
      vph_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      ang_q   <= ang_d;
      tbl_q   <= tbl_d;
      md_q    <= md_d;
      three_q <= three_d;
      vld_q   <= vld_d;
      vph_q   <= vph_d;
      done_q  <= done_d;
    end
  end

  assign rd_en_o   = busy_q;
  assign rd_addr_o = {tbl_q, idx};
  assign busy_o    = busy_q;
  assign mdval_o   = md_q;
  assign three_o   = three_q;
  assign load_o    = vld_q;
  assign load_ph_o = vph_q;
  assign done_o    = done_q;
endmodule

// File: rtl/wlut_scale.sv
module wlut_scale #(
  parameter int DATA_W = 18,
  parameter int MAG_W  = 17
) (
  input  logic [DATA_W-1:0] entry_i,
  input  logic [MAG_W-1:0]  mdval_i,
  input  logic              three_i,
  output logic [MAG_W-1:0]  duty_o,
  output logic              neg_o
);
  localparam int PROD_W = 2 * MAG_W;

  logic [DATA_W-1:0] abs_v;
  logic [MAG_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic              sgn;

  assign sgn   = entry_i[DATA_W-1];
  assign abs_v = sgn ? (~entry_i + DATA_W'(1)) : entry_i;

  always_comb begin
    if (three_i) begin
      neg_o = 1'b0;
      mag   = sgn ? '0 : entry_i[MAG_W-1:0];
    end else begin
      neg_o = sgn;
      mag   = (|abs_v[DATA_W-1:MAG_W]) ? '1 : abs_v[MAG_W-1:0];
    end
  end

  assign prod   = PROD_W'(mdval_i) * PROD_W'(mag);
  assign duty_o = MAG_W'(prod >> MAG_W);
endmodule

// File: rtl/wave_lut_scaler.sv
module wave_lut_scaler
  import wlut_pkg::*;
#(
  parameter int ANGLE_W = 25,
  parameter int IDX_W   = 8,
  parameter int TBL_W   = 2,
  parameter int DATA_W  = 18,
  parameter int MAG_W   = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en_i,
  input  logic                     acc_we_i,
  input  logic [TBL_W+IDX_W-1:0]   acc_addr_i,
  input  logic [DATA_W-1:0]        acc_wdata_i,
  output logic [DATA_W-1:0]        acc_rdata_o,
  input  logic                     start_i,
  input  logic                     three_phase_i,
  input  logic [TBL_W-1:0]         tbl_sel_i,
  input  logic [ANGLE_W-1:0]       angle_i,
  input  logic [MAG_W-1:0]         mdval_i,
  output logic [NUM_PH*MAG_W-1:0]  duty_o,
  output logic [NUM_PH-1:0]        neg_o,
  output logic                     done_o
);
  localparam int ADDR_W = TBL_W + IDX_W;
  localparam int PH_W   = $clog2(NUM_PH);

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              busy;
  logic [MAG_W-1:0]  mdval_q;
  logic              three_q;
  logic              load;
  logic [PH_W-1:0]   load_ph;
  logic [MAG_W-1:0]  duty_calc;
  logic              neg_calc;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wlut_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .a_en    (acc_en_i),
    .a_we    (acc_we_i),
    .a_addr  (acc_addr_i),
    .a_wdata (acc_wdata_i),
    .a_rdata (acc_rdata_o),
    .b_en    (rd_en),
    .b_addr  (rd_addr),
    .b_rdata (rd_data)
  );

  wlut_seq #(
    .ANGLE_W(ANGLE_W), .IDX_W(IDX_W), .TBL_W(TBL_W), .MAG_W(MAG_W), .PH_W(PH_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .angle_i   (angle_i),
    .tbl_i     (tbl_sel_i),
    .mdval_i   (mdval_i),
    .three_i   (three_phase_i),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .busy_o    (busy),
    .mdval_o   (mdval_q),
    .three_o   (three_q),
    .load_o    (load),
    .load_ph_o (load_ph),
    .done_o    (done_o)
  );

  wlut_scale #(.DATA_W(DATA_W), .MAG_W(MAG_W)) u_scale (
    .entry_i (rd_data),
    .mdval_i (mdval_q),
    .three_i (three_q),
    .duty_o  (duty_calc),
    .neg_o   (neg_calc)
  );

  // One duty/polarity register per phase; phases beyond the two-coil
  // count are cleared when a two-coil lookup loads phase 0.
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic [MAG_W-1:0] duty_q, duty_d;
    logic             neg_q, neg_d;
    logic             hit, clr;

    assign hit = load & (load_ph == PH_W'(p));
    assign clr = (p >= 2) & load & (load_ph == '0) & (three_q == MODE_TWO_COIL);

    always_comb begin
      duty_d = duty_q;
      neg_d  = neg_q;
      if (hit) begin
        duty_d = duty_calc;
        neg_d  = neg_calc;
      end else if (clr) begin
        duty_d = '0;
        neg_d  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        duty_q <= '0;
        neg_q  <= 1'b0;
      end else begin
        duty_q <= duty_d;
        neg_q  <= neg_d;
      end
    end

    assign duty_o[p*MAG_W +: MAG_W] = duty_q;
    assign neg_o[p]                 = neg_q;
  end
endmodule

// File: rtl/wave_lut_scaler_chk.sv
module wave_lut_scaler_chk #(
  parameter int MAG_W  = 17,
  parameter int DATA_W = 18,
  parameter int NPH    = 3
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 start_i,
  input logic                 busy,
  input logic                 done_o,
  input logic                 acc_en_i,
  input logic                 acc_we_i,
  input logic [DATA_W-1:0]    acc_rdata_o,
  input logic                 three_q,
  input logic [MAG_W-1:0]     mdval_q,
  input logic [NPH*MAG_W-1:0] duty_o,
  input logic [NPH-1:0]       neg_o
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(acc_en_i && !acc_we_i) |=> $stable(acc_rdata_o));

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy) |=> busy);

  // R5
  two_coil_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && !three_q) |-> (duty_o[2*MAG_W +: MAG_W] == '0 && !neg_o[2]));

  // R7
  three_pos_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && three_q) |-> (neg_o == '0));

  for (genvar p = 0; p < NPH; p++) begin : g_bound
    // R6
    duty_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      done_o |-> (duty_o[p*MAG_W +: MAG_W] <= mdval_q));
  end
endmodule

bind wave_lut_scaler wave_lut_scaler_chk #(.MAG_W(MAG_W), .DATA_W(DATA_W), .NPH(wlut_pkg::NUM_PH)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .start_i     (start_i),
  .busy        (busy),
  .done_o      (done_o),
  .acc_en_i    (acc_en_i),
  .acc_we_i    (acc_we_i),
  .acc_rdata_o (acc_rdata_o),
  .three_q     (three_q),
  .mdval_q     (mdval_q),
  .duty_o      (duty_o),
  .neg_o       (neg_o)
);

// File: tb/wave_lut_scaler_tb.sv
module wave_lut_scaler_tb;
  logic        clk;
  logic        rst_n;
  logic        acc_en_i, acc_we_i;
  logic [9:0]  acc_addr_i;
  logic [17:0] acc_wdata_i;
  logic [17:0] acc_rdata_o;
  logic        start_i, three_phase_i;
  logic [1:0]  tbl_sel_i;
  logic [24:0] angle_i;
  logic [16:0] mdval_i;
  logic [50:0] duty_o;
  logic [2:0]  neg_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  logic [17:0] shadow [1024];

  wave_lut_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en_i(acc_en_i), .acc_we_i(acc_we_i),
    .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o),
    .start_i(start_i), .three_phase_i(three_phase_i), .tbl_sel_i(tbl_sel_i),
    .angle_i(angle_i), .mdval_i(mdval_i), .duty_o(duty_o), .neg_o(neg_o),
    .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_duty(input logic three, input int p,
      input logic [24:0] ang, input logic [1:0] tb, input logic [16:0] md,
      output logic n);
    logic [24:0] ofs, sum;
    logic [17:0] e, a;
    logic [16:0] mag;
    logic [33:0] prod;
    n = 1'b0;
    if (!three && p == 2) return 17'd0;
    if (three) ofs = (p == 1) ? 25'd22369621 : (p == 2) ? 25'd11184810 : 25'd0;
    else       ofs = (p == 1) ? 25'd25165824 : 25'd0;
    sum = ang + ofs;
    e = shadow[{tb, sum[24:17]}];
    if (three) begin
      mag = e[17] ? 17'd0 : e[16:0];
    end else begin
      n = e[17];
      a = e[17] ? (~e + 18'd1) : e;
      mag = a[17] ? 17'h1FFFF : a[16:0];
    end
    prod = 34'(md) * 34'(mag);
    return prod[33:17];
  endfunction

  task automatic mem_write(input logic [9:0] addr, input logic [17:0] data);
    @(negedge clk);
    acc_en_i = 1'b1; acc_we_i = 1'b1; acc_addr_i = addr; acc_wdata_i = data;
    shadow[addr] = data;
    @(negedge clk);
    acc_en_i = 1'b0; acc_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(duty_o == '0, "R1 duty", longint'(duty_o), 0);
    chk(neg_o == '0, "R1 neg", longint'(neg_o), 0);
    chk(done_o == 1'b0, "R1 done", longint'(done_o), 0);
    chk(acc_rdata_o == '0, "R1 rdata", longint'(acc_rdata_o), 0);
  endtask

  task automatic t_fill;
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 256; i++) begin
        int v;
        v = ((t * 7919 + i * 613 + 12345) % 262144) - 131072;
        mem_write(10'(t * 256 + i), 18'(v));
      end
    end
    mem_write(10'h300, 18'h1FFFF);
    mem_write(10'h3C0, 18'h20000);
  endtask

  task automatic t_access;
    logic [17:0] held;
    for (int k = 0; k < 4; k++) begin
      logic [9:0] a;
      a = 10'(k * 257 + 3);
      @(negedge clk);
      acc_en_i = 1'b1; acc_we_i = 1'b0; acc_addr_i = a;
      @(negedge clk);
      acc_en_i = 1'b0;
      chk(acc_rdata_o == shadow[a], "R2 read", longint'(acc_rdata_o), longint'(shadow[a]));
    end
    held = acc_rdata_o;
    mem_write(10'h011, 18'h00ABC);
    @(negedge clk);
    chk(acc_rdata_o == held, "R2 hold", longint'(acc_rdata_o), longint'(held));
    @(negedge clk);
    acc_en_i = 1'b1; acc_we_i = 1'b0; acc_addr_i = 10'h011;
    @(negedge clk);
    acc_en_i = 1'b0;
    chk(acc_rdata_o == 18'h00ABC, "R2 readback", longint'(acc_rdata_o), 18'h00ABC);
  endtask

  // Runs one lookup; dbl issues a second start while busy (R3),
  // coll writes the phase-0 entry on the edge that reads it (R10).
  task automatic run_lookup(input logic three, input logic [1:0] tb,
      input logic [24:0] ang, input logic [16:0] md, input string req,
      input logic dbl, input logic coll, input logic [17:0] cdata);
    logic [16:0] ed [3];
    logic        en [3];
    int          nph;
    logic [9:0]  caddr;
    nph = three ? 3 : 2;
    for (int p = 0; p < 3; p++) ed[p] = exp_duty(three, p, ang, tb, md, en[p]);
    caddr = {tb, ang[24:17]};
    @(negedge clk);
    start_i = 1'b1; three_phase_i = three; tbl_sel_i = tb; angle_i = ang; mdval_i = md;
    @(negedge clk);
    start_i = 1'b0;
    if (dbl) begin
      start_i = 1'b1; angle_i = ang + 25'h0800000; tbl_sel_i = tb + 2'd1; mdval_i = ~md;
    end
    if (coll) begin
      acc_en_i = 1'b1; acc_we_i = 1'b1; acc_addr_i = caddr; acc_wdata_i = cdata;
    end
    for (int k = 1; k <= nph; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (k == 1 && coll) begin
        acc_en_i = 1'b0; acc_we_i = 1'b0;
        shadow[caddr] = cdata;
      end
      chk(done_o == 1'b0, "R9 early", longint'(done_o), 0);
    end
    @(negedge clk);
    chk(done_o == 1'b1, "R9 done", longint'(done_o), 1);
    for (int p = 0; p < 3; p++) begin
      chk(duty_o[p*17 +: 17] == ed[p], req, longint'(duty_o[p*17 +: 17]), longint'(ed[p]));
      chk(neg_o[p] == en[p], req, longint'(neg_o[p]), longint'(en[p]));
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R9 pulse", longint'(done_o), 0);
    @(negedge clk);
    chk(duty_o[16:0] == ed[0], "R9 hold", longint'(duty_o[16:0]), longint'(ed[0]));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; acc_en_i = 1'b0; acc_we_i = 1'b0; acc_addr_i = '0; acc_wdata_i = '0;
    start_i = 1'b0; three_phase_i = 1'b1; tbl_sel_i = '0; angle_i = '0; mdval_i = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_fill;
    t_access;
    // R4 three-phase indexing and R6/R7 scaling
    run_lookup(1'b1, 2'd0, 25'd1234567, 17'd100000, "R4 three-phase", 1'b0, 1'b0, '0);
    run_lookup(1'b1, 2'd1, 25'h1FFFFFF, 17'd131071, "R4 wrap", 1'b0, 1'b0, '0);
    run_lookup(1'b1, 2'd2, 25'd20000000, 17'd77777, "R7 clamp", 1'b0, 1'b0, '0);
    run_lookup(1'b1, 2'd3, 25'd0, 17'd0, "R6 zero mdval", 1'b0, 1'b0, '0);
    // R5 two-coil offsets, R8 sign and cap
    run_lookup(1'b0, 2'd3, 25'd0, 17'd131071, "R8 boundary", 1'b0, 1'b0, '0);
    run_lookup(1'b0, 2'd2, 25'd9999999, 17'd65536, "R5 two-coil", 1'b0, 1'b0, '0);
    // R3 start while busy is ignored
    run_lookup(1'b1, 2'd1, 25'd5555555, 17'd40000, "R3 busy start", 1'b1, 1'b0, '0);
    // R10 collision: old data, then new data
    run_lookup(1'b1, 2'd0, 25'd3000000, 17'd120000, "R10 old data", 1'b0, 1'b1, 18'h15555);
    run_lookup(1'b1, 2'd0, 25'd3000000, 17'd120000, "R10 new data", 1'b0, 1'b0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule